// File: doc/BRIEF.md
# Prescaled Module Clock Generator

This block derives a slow module clock from a fast parent. Four parent sources arrive as per-cycle tick enables inside one clock domain. A two-bit source select picks one of them. The selected ticks pass through a power-of-two prescaler and then an integer divider, so one output period spans `(m+1) << p` source ticks.

All control is held in one 32-bit configuration word, written and read through a simple synchronous port. The word has an enable bit, a source select, a prescale exponent and a divide value. The block produces two outputs. `mod_tick` is a single-cycle enable that marks the start of each output period. `mod_clk` is a level that is high for the first half of each period. Downstream logic uses `mod_tick` as a clock enable and `mod_clk` as a waveform.

Configuration changes are held back until the running period ends, so a change never cuts a period short. Clearing the enable lets a high phase already in progress finish, then parks the output low.

Top module: `modclk_gen`

## Requirements
- R1: A write (`wr_en` high at a rising edge) stores bit 31 (enable), bits 25:24 (source select), bits 17:16 (prescale exponent p) and bits 3:0 (divide value m). `rd_data` shows the stored word from the next cycle, and every other bit reads as 0.
- R2: While enabled and fed by a source that ticks every cycle, consecutive `mod_tick` pulses are exactly N = (m+1)·2^p cycles apart, for every p in 0..3 and every m in 0..15.
- R3: Within each period, `mod_clk` is high for floor(N/2) source ticks, starting at the `mod_tick` cycle. With N = 1, `mod_clk` stays low and `mod_tick` is asserted on every source tick.
- R4: Select value s makes only `src_tick[s]` advance the divider. Activity on the other source inputs does not change the output timing.
- R5: New select, p or m values written while running take effect only at the next period boundary. The period in progress completes with the old values, and `mod_clk` only falls one cycle after a source tick.
- R6: Once the enable bit is cleared, a high phase already in progress runs to its normal end. After that, `mod_clk` stays low and no `mod_tick` is produced until the bit is set again, which restarts with a full period.
- R7: `mod_tick` is asserted only in cycles where a source tick is present, so the output never runs faster than the selected parent.
- R8: After reset, `rd_data` is 0 and both `mod_clk` and `mod_tick` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast parent clock of the domain |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | Per-cycle tick enable of each parent source |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Stored configuration word |
| mod_clk | output | 1 | Divided module clock level |
| mod_tick | output | 1 | One-cycle enable at the start of each output period |

## Verification
The assertions check four properties on every cycle:
- a write lands in the masked configuration word;
- a `mod_tick` only appears alongside a source tick;
- `mod_clk` only falls right after a tick;
- once the output is disabled and low, it stays quiet.

Exact period lengths and high-phase widths for each p and m need the bench's scenarios, because they are counts over many cycles. The same holds for a change deferred to the next boundary, for the select ignoring the other sources, and for a restart after re-enable.

// File: rtl/modclk_gen.sv
module modclk_gen #(
  parameter int DIV_W = 4,
  parameter int PRE_W = 2,
  parameter int SEL_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<SEL_W)-1:0] src_tick,
  input  logic                  wr_en,
  input  logic [31:0]           wr_data,
  output logic [31:0]           rd_data,
  output logic                  mod_clk,
  output logic                  mod_tick
);
  localparam int EN_B   = 31;
  localparam int SEL_LO = 24;
  localparam int PRE_LO = 16;
  localparam int DIV_LO = 0;
  localparam int CW     = DIV_W + (1 << PRE_W) - 1;

  logic             en_q, running;
  logic [SEL_W-1:0] sel_q, sel_a;
  logic [PRE_W-1:0] pre_q, pre_a;
  logic [DIV_W-1:0] div_q, div_a;
  logic [CW-1:0]    cnt;
  logic [CW:0]      ratio, half;
  logic             tick, last, in_high;

  assign ratio   = (CW+1)'({1'b0, div_a} + 1'b1) << pre_a;
  assign half    = ratio >> 1;
  assign tick    = src_tick[sel_a];
  assign last    = ({1'b0, cnt} == ratio - 1'b1);
  assign in_high = ({1'b0, cnt} < half);

  assign mod_clk  = running && in_high;
  assign mod_tick = running && tick && (cnt == '0);

  always_comb begin
    rd_data = '0;
    rd_data[EN_B] = en_q;
    rd_data[SEL_LO +: SEL_W] = sel_q;
    rd_data[PRE_LO +: PRE_W] = pre_q;
    rd_data[DIV_LO +: DIV_W] = div_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      sel_q   <= '0;
      pre_q   <= '0;
      div_q   <= '0;
      sel_a   <= '0;
      pre_a   <= '0;
      div_a   <= '0;
      running <= 1'b0;
      cnt     <= '0;
    end else begin
      if (wr_en) begin
        en_q  <= wr_data[EN_B];
        sel_q <= wr_data[SEL_LO +: SEL_W];
        pre_q <= wr_data[PRE_LO +: PRE_W];
        div_q <= wr_data[DIV_LO +: DIV_W];
      end
      if (!running) begin
        cnt <= '0;
        if (en_q) begin
          running <= 1'b1;
          sel_a   <= sel_q;
          pre_a   <= pre_q;
          div_a   <= div_q;
        end
      end else if (!en_q && !in_high) begin
        running <= 1'b0;
        cnt     <= '0;
      end else if (tick) begin
        if (last) begin
          cnt   <= '0;
          sel_a <= sel_q;
          pre_a <= pre_q;
          div_a <= div_q;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/modclk_gen_chk.sv
module modclk_gen_chk #(
  parameter int SRC_N = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_N-1:0] src_tick,
  input logic             wr_en,
  input logic [31:0]      wr_data,
  input logic [31:0]      rd_data,
  input logic             mod_clk,
  input logic             mod_tick
);
  localparam logic [31:0] KEEP = 32'h8303_000F;

  a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == ($past(wr_data) & KEEP));

  a_r7_tick_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    mod_tick |-> (|src_tick));

  a_r5_fall_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_clk) |-> $past(|src_tick));

  a_r6_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[31] && !mod_clk) |=> !mod_clk);

  a_r6_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[31] && !mod_clk) |=> !mod_tick);
endmodule

bind modclk_gen modclk_gen_chk #(.SRC_N(4)) chk (.*);

// File: tb/modclk_gen_test.sv
module modclk_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mod_clk, mod_tick;

  int total = 0, fails = 0;
  bit done = 0;
  int src_div [4] = '{1, 1, 1, 1};
  int src_ph  [4] = '{0, 0, 0, 0};

  modclk_gen uut (.*);

  always #2 clk = ~clk;

  initial begin
    forever begin
      @(posedge clk); #1;
      for (int i = 0; i < 4; i++) begin
        if (src_div[i] == 0) src_tick[i] = 1'($urandom % 2);
        else begin
          src_tick[i] = (src_ph[i] == 0);
          src_ph[i] = (src_ph[i] + 1) % src_div[i];
        end
      end
    end
  end

  function automatic int exp_n(int p, int m); return (m + 1) << p; endfunction
  function automatic logic [31:0] cfg(bit en, int s, int p, int m);
    return {en, 5'd0, 2'(s), 6'd0, 2'(p), 12'd0, 4'(m)};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write(logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reconfig(logic [31:0] d);
    write(32'd0);
    for (int i = 0; i < 300 && mod_clk; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    write(d);
  endtask

  task automatic wait_tick();
    for (int i = 0; i < 500 && !mod_tick; i++) @(negedge clk);
  endtask

  task automatic measure(output int per, output int hi);
    per = 0; hi = 0;
    do begin
      if (mod_clk) hi++;
      per++;
      @(negedge clk);
    end while (!mod_tick && per < 500);
  endtask

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int per, hi, hc, cnt;
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 rd_data", int'(rd_data), 0);
    check("R8 mod_clk", int'(mod_clk), 0);
    check("R8 mod_tick", int'(mod_tick), 0);

    // R2/R3 sweep of every prescale and divide value
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 16; m++) begin
        reconfig(cfg(1, 0, p, m));
        wait_tick();
        measure(per, hi);
        check($sformatf("R2 period p=%0d m=%0d", p, m), per, exp_n(p, m));
        check($sformatf("R3 high p=%0d m=%0d", p, m), hi, exp_n(p, m) / 2);
      end

    // R1 random words with random select
    for (int k = 0; k < 24; k++) begin
      d = $urandom;
      reconfig(d);
      @(negedge clk);
      check("R1 readback", int'(rd_data), int'(d & 32'h8303_000F));
      if (d[31]) begin
        wait_tick();
        measure(per, hi);
        check("R2 random period", per, exp_n(d[17:16], d[3:0]));
      end
    end

    // R4/R7: source 2 ticks every 3 cycles, others random
    src_div = '{0, 0, 3, 0};
    reconfig(cfg(1, 2, 1, 2));
    wait_tick();
    cnt = 0;
    for (int r = 0; r < 3; r++) begin
      per = 0;
      do begin
        if (mod_tick && !src_tick[2]) cnt++;
        per++;
        @(negedge clk);
      end while (!mod_tick && per < 500);
      check("R4 period on source 2", per, 18);
    end
    check("R7 ticks without source", cnt, 0);
    src_div = '{1, 1, 1, 1};

    // R5: change divide mid-period
    reconfig(cfg(1, 0, 0, 9));
    wait_tick();
    per = 0;
    @(negedge clk); per++;
    wr_en = 1'b1; wr_data = cfg(1, 0, 0, 3);
    @(negedge clk); per++;
    wr_en = 1'b0;
    while (!mod_tick && per < 500) begin @(negedge clk); per++; end
    check("R5 old period completes", per, 10);
    measure(per, hi);
    check("R5 new period", per, 4);
    check("R5 new high", hi, 2);

    // R6: disable in high phase
    reconfig(cfg(1, 0, 0, 15));
    wait_tick();
    hc = 1;
    @(negedge clk); if (mod_clk) hc++;
    wr_en = 1'b1; wr_data = cfg(0, 0, 0, 15);
    @(negedge clk); if (mod_clk) hc++;
    wr_en = 1'b0;
    while (mod_clk && hc < 500) begin @(negedge clk); if (mod_clk) hc++; end
    check("R6 high phase finishes", hc, 8);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (mod_clk || mod_tick) cnt++;
      @(negedge clk);
    end
    check("R6 quiet while off", cnt, 0);
    write(cfg(1, 0, 0, 15));
    wait_tick();
    measure(per, hi);
    check("R6 restart period", per, 16);
    check("R6 restart high", hi, 8);

    // R3: unity ratio follows every tick
    reconfig(cfg(1, 3, 0, 0));
    wait_tick();
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      if (mod_tick && !mod_clk) cnt++;
      @(negedge clk);
    end
    check("R3 unity ratio", cnt, 20);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule